// File: doc/BRIEF.md
# Event-Driven Module Scheduler

This block sequences work for an array of processing tiles. A module is a unit of work whose activity is triggered by its input signals. The scheduler keeps a table of module slots and a connectivity directory that lists, for every signal, the slots that must react when that signal is written. A tile that writes a signal reports the write as an update event. The scheduler never stalls that write. It looks the signal up in the directory and moves every waiting module that reacts to it into a ready queue.

Ready modules are taken in arrival order and offered to a free tile. A round-robin pointer rotates through the tiles. The offer is a valid/ready handshake. When a tile reports that it has finished, its module goes back to waiting and the tile becomes free again. New modules can be written into free slots while the array runs, for example when a running module spawns another instance. The state of every slot and the tile each module runs on can be read at the ports at all times.

Top module: `event_scheduler`

## Requirements
- R1: After reset, every slot reads as free (state code 0), the ready queue count is 0 and `dispValid` is low.
- R2: An add request to a free slot makes it waiting (code 1) and writes its sensitivity mask into the directory. Bit s of `addSens` means the module reacts to signal s. An add request to an occupied slot is ignored, so its state and its sensitivity are unchanged.
- R3: At the clock edge where `updMask` has a bit set, every waiting module sensitive to that signal becomes ready (code 2), and `readyCount` grows by the number of modules woken.
- R4: When several modules wake at one edge, all of them are queued together. They go behind the entries already queued, in ascending slot order, and are offered in that order.
- R5: An update event for a module that is ready or running has no effect: it is not queued a second time and its state does not change.
- R6: Update events are accepted in every cycle with no back-pressure. A module woken at the same edge as a dispatch transfer joins the queue behind the remaining entries.
- R7: `dispValid` is high whenever the queue is non-empty and a tile is free, with `dispMod` naming the queue head. On `dispValid && dispReady` the head leaves the queue, its state becomes running (code 3) and the granted tile becomes busy.
- R8: The tile offered is the first free tile at or after the position one past the last granted tile, wrapping around. The pointer starts at tile 0.
- R9: When all tiles are busy, `dispValid` stays low even if the queue is non-empty.
- R10: A completion on a busy tile returns the module running there to waiting and frees the tile. A completion on a free tile is ignored.
- R11: `modStateVec[2m+1:2m]` holds slot m's state code, and `modTileVec[2m+1:2m]` holds the tile it was last dispatched to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updMask | input | 32 | One bit per signal written this cycle |
| addValid | input | 1 | Request to install a module in a slot |
| addId | input | 4 | Slot to install |
| addSens | input | 32 | Sensitivity mask of the installed module |
| dispValid | output | 1 | A ready module is offered to a free tile |
| dispMod | output | 4 | Slot offered |
| dispTile | output | 2 | Tile chosen for the offer |
| dispReady | input | 1 | Tile side accepts the offer |
| doneValid | input | 1 | Completion notice |
| doneTile | input | 2 | Tile that finished |
| modStateVec | output | 32 | Two-bit state code per slot |
| modTileVec | output | 32 | Two-bit tile number per slot |
| readyCount | output | 5 | Number of modules in the ready queue |

## Verification
The ready queue can take wake-ups and lose its head in the same cycle. Wake-ups can also arrive in groups, so the queue can both grow by several entries and shrink by one at a single edge. The bench provokes this by raising `updMask` in the very cycle it asserts `dispReady`. A module that has just returned to waiting is picked as the target, so the wake is real. A reference queue in the bench predicts the count and the order of later offers, and the checks compare the ports against it. The bench also sweeps every single signal and several multi-signal patterns against masks it computes itself. Each queue drain checks order, tile rotation and each return to waiting.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int MOD_SLOTS  = 16;
  localparam int SIG_COUNT  = 32;
  localparam int TILE_COUNT = 4;
  localparam int MOD_W      = $clog2(MOD_SLOTS);
  localparam int TILE_W     = $clog2(TILE_COUNT);
  localparam int CNT_W      = $clog2(MOD_SLOTS + 1);

  typedef logic [MOD_W-1:0]  modId_t;
  typedef logic [TILE_W-1:0] tileId_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {
    MS_FREE  = 2'd0,
    MS_WAIT  = 2'd1,
    MS_READY = 2'd2,
    MS_RUN   = 2'd3
  } modState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [MOD_SLOTS-1:0] wakeMask;
    logic                 addWr;
    logic                 pop;
    tileId_t              fireTile;
  } schedStrobe_t;
endpackage

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  schedStrobe_t               strb,
  input  modId_t                     addId,
  input  logic [SIG_COUNT-1:0]       addSens,
  input  logic [SIG_COUNT-1:0]       updMask,
  input  tileId_t                    doneTile,
  output logic [MOD_SLOTS-1:0]       updHit,
  output modId_t                     headMod,
  output logic                       queueEmpty,
  output modId_t                     doneMod,
  output logic [TILE_W*MOD_SLOTS-1:0] modTileVec,
  output cnt_t                       readyCount
);
  // connectivity directory: per signal, the set of sink slots
  logic [MOD_SLOTS-1:0] sinkDir [SIG_COUNT];

  // ready queue ring
  modId_t ring [MOD_SLOTS];
  modId_t headPtr, tailPtr;
  cnt_t   occ;

  // location tables
  tileId_t modTile [MOD_SLOTS];
  modId_t  tileMod [TILE_COUNT];

  modId_t slotPos [MOD_SLOTS];
  int     rank;

  always_comb begin
    updHit = '0;
    for (int s = 0; s < SIG_COUNT; s++) begin
      if (updMask[s]) updHit = updHit | sinkDir[s];
    end
  end

  // each woken slot gets its own write position: tail plus number of lower woken slots
  always_comb begin
    rank = 0;
    for (int m = 0; m < MOD_SLOTS; m++) begin
      slotPos[m] = modId_t'((int'(tailPtr) + rank) % MOD_SLOTS);
      if (strb.wakeMask[m]) rank = rank + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SIG_COUNT; s++) sinkDir[s] <= '0;
    end else if (strb.addWr) begin
      for (int s = 0; s < SIG_COUNT; s++) sinkDir[s][addId] <= addSens[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      occ     <= '0;
      for (int m = 0; m < MOD_SLOTS; m++) ring[m] <= '0;
    end else begin
      for (int m = 0; m < MOD_SLOTS; m++) begin
        if (strb.wakeMask[m]) ring[slotPos[m]] <= modId_t'(m);
      end
      if (strb.pop) headPtr <= modId_t'((int'(headPtr) + 1) % MOD_SLOTS);
      tailPtr <= modId_t'((int'(tailPtr) + rank) % MOD_SLOTS);
      occ     <= cnt_t'(int'(occ) + rank - (strb.pop ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < MOD_SLOTS; m++) modTile[m] <= '0;
      for (int t = 0; t < TILE_COUNT; t++) tileMod[t] <= '0;
    end else if (strb.pop) begin
      modTile[headMod]       <= strb.fireTile;
      tileMod[strb.fireTile] <= headMod;
    end
  end

  assign headMod    = ring[headPtr];
  assign queueEmpty = (occ == '0);
  assign doneMod    = tileMod[doneTile];
  assign readyCount = occ;

  for (genvar g = 0; g < MOD_SLOTS; g++) begin : gTileOut
    assign modTileVec[TILE_W*g +: TILE_W] = modTile[g];
  end

  // R4: queue never holds more entries than there are slots
  a_r4_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(occ) <= MOD_SLOTS);

  // R7: a transfer only happens from a non-empty queue
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !queueEmpty);

  // R11: a dispatched slot records the tile it was sent to
  a_r11_tile_recorded: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> modTile[$past(headMod)] == $past(strb.fireTile));
endmodule

// File: rtl/sched_control.sv
module sched_control
  import sched_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [MOD_SLOTS-1:0]   updHit,
  input  logic                   queueEmpty,
  input  modId_t                 headMod,
  input  modId_t                 doneMod,
  input  logic                   addValid,
  input  modId_t                 addId,
  input  logic                   dispReady,
  input  logic                   doneValid,
  input  tileId_t                doneTile,
  output schedStrobe_t           strb,
  output logic                   dispValid,
  output tileId_t                dispTile,
  output logic [2*MOD_SLOTS-1:0] modStateVec
);
  modState_e             modState [MOD_SLOTS];
  logic [TILE_COUNT-1:0] tileBusy;
  tileId_t               rrPtr;

  tileId_t grantTile;
  tileId_t cand;
  logic    anyFree;
  logic    fire;
  logic    doneAct;
  logic    addOk;
  logic [MOD_SLOTS-1:0] wake;

  // round-robin search starting at the pointer
  always_comb begin
    grantTile = '0;
    cand      = '0;
    anyFree   = 1'b0;
    for (int i = 0; i < TILE_COUNT; i++) begin
      cand = tileId_t'((int'(rrPtr) + i) % TILE_COUNT);
      if (!anyFree && !tileBusy[cand]) begin
        anyFree   = 1'b1;
        grantTile = cand;
      end
    end
  end

  always_comb begin
    for (int m = 0; m < MOD_SLOTS; m++) begin
      wake[m] = (modState[m] == MS_WAIT) && updHit[m];
    end
  end

  assign dispValid = !queueEmpty && anyFree;
  assign dispTile  = grantTile;
  assign fire      = dispValid && dispReady;
  assign doneAct   = doneValid && tileBusy[doneTile];
  assign addOk     = addValid && (modState[addId] == MS_FREE);

  always_comb begin
    strb.wakeMask = wake;
    strb.addWr    = addOk;
    strb.pop      = fire;
    strb.fireTile = grantTile;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < MOD_SLOTS; m++) modState[m] <= MS_FREE;
    end else begin
      for (int m = 0; m < MOD_SLOTS; m++) begin
        if (wake[m]) modState[m] <= MS_READY;
        else if (fire && headMod == modId_t'(m)) modState[m] <= MS_RUN;
        else if (doneAct && doneMod == modId_t'(m)) modState[m] <= MS_WAIT;
        else if (addOk && addId == modId_t'(m)) modState[m] <= MS_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileBusy <= '0;
      rrPtr    <= '0;
    end else begin
      if (fire) begin
        tileBusy[grantTile] <= 1'b1;
        rrPtr <= tileId_t'((int'(grantTile) + 1) % TILE_COUNT);
      end
      if (doneAct) tileBusy[doneTile] <= 1'b0;
    end
  end

  for (genvar g = 0; g < MOD_SLOTS; g++) begin : gSlot
    assign modStateVec[2*g +: 2] = modState[g];

    // R3: a waiting slot hit by an update is ready at the next cycle
    a_r3_wake: assert property (@(posedge clk) disable iff (!rstN)
      (modState[g] == MS_WAIT && updHit[g]) |=> modState[g] == MS_READY);

    // R5: a running slot stays running until its tile completes
    a_r5_run_hold: assert property (@(posedge clk) disable iff (!rstN)
      (modState[g] == MS_RUN && !(doneAct && doneMod == modId_t'(g)))
        |=> modState[g] == MS_RUN);

    // R7: the accepted head becomes running
    a_r7_fire_run: assert property (@(posedge clk) disable iff (!rstN)
      (fire && headMod == modId_t'(g)) |=> modState[g] == MS_RUN);
  end

  // R8: the offered tile is never one that is busy
  a_r8_grant_free: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> !tileBusy[dispTile]);

  // R9: no offer while every tile is busy
  a_r9_no_offer_full: assert property (@(posedge clk) disable iff (!rstN)
    (&tileBusy) |-> !dispValid);

  // R10: a completion frees its tile
  a_r10_done_frees: assert property (@(posedge clk) disable iff (!rstN)
    doneAct |=> !tileBusy[$past(doneTile)]);
endmodule

// File: rtl/event_scheduler.sv
module event_scheduler
  import sched_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SIG_COUNT-1:0]        updMask,
  input  logic                        addValid,
  input  logic [MOD_W-1:0]            addId,
  input  logic [SIG_COUNT-1:0]        addSens,
  output logic                        dispValid,
  output logic [MOD_W-1:0]            dispMod,
  output logic [TILE_W-1:0]           dispTile,
  input  logic                        dispReady,
  input  logic                        doneValid,
  input  logic [TILE_W-1:0]           doneTile,
  output logic [2*MOD_SLOTS-1:0]      modStateVec,
  output logic [TILE_W*MOD_SLOTS-1:0] modTileVec,
  output logic [CNT_W-1:0]            readyCount
);
  schedStrobe_t         strb;
  logic [MOD_SLOTS-1:0] updHit;
  modId_t               headMod;
  modId_t               doneMod;
  logic                 queueEmpty;

  sched_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .updHit     (updHit),
    .queueEmpty (queueEmpty),
    .headMod    (headMod),
    .doneMod    (doneMod),
    .addValid   (addValid),
    .addId      (addId),
    .dispReady  (dispReady),
    .doneValid  (doneValid),
    .doneTile   (doneTile),
    .strb       (strb),
    .dispValid  (dispValid),
    .dispTile   (dispTile),
    .modStateVec(modStateVec)
  );

  sched_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addId      (addId),
    .addSens    (addSens),
    .updMask    (updMask),
    .doneTile   (doneTile),
    .updHit     (updHit),
    .headMod    (headMod),
    .queueEmpty (queueEmpty),
    .doneMod    (doneMod),
    .modTileVec (modTileVec),
    .readyCount (readyCount)
  );

  assign dispMod = headMod;
endmodule

// File: tb/event_scheduler_bench.sv
module event_scheduler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 16;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] updMask;
  logic        addValid;
  logic [3:0]  addId;
  logic [31:0] addSens;
  logic        dispValid;
  logic [3:0]  dispMod;
  logic [1:0]  dispTile;
  logic        dispReady;
  logic        doneValid;
  logic [1:0]  doneTile;
  logic [31:0] modStateVec;
  logic [31:0] modTileVec;
  logic [4:0]  readyCount;

  event_scheduler u_event_scheduler (
    .clk(clk), .rstN(rstN), .updMask(updMask), .addValid(addValid),
    .addId(addId), .addSens(addSens), .dispValid(dispValid),
    .dispMod(dispMod), .dispTile(dispTile), .dispReady(dispReady),
    .doneValid(doneValid), .doneTile(doneTile), .modStateVec(modStateVec),
    .modTileVec(modTileVec), .readyCount(readyCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0;
  int nErr = 0;
  int st [NM];
  int tl [NM];
  logic [31:0] sens [NM];
  bit busyM [NT];
  int ptrM = 0;
  int q[$];

  function automatic logic [31:0] sensOf(int m);
    return (32'h1 << m) | (32'h1 << (16 + m / 4));
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkState(string tag);
    logic [31:0] expV;
    expV = '0;
    for (int m = 0; m < NM; m++) expV[2*m +: 2] = 2'(st[m]);
    chk(modStateVec == expV, tag, 64'(modStateVec), 64'(expV));
    chk(int'(readyCount) == q.size(), tag, 64'(readyCount), 64'(q.size()));
  endtask

  function automatic int grantM();
    for (int i = 0; i < NT; i++) begin
      if (!busyM[(ptrM + i) % NT]) return (ptrM + i) % NT;
    end
    return -1;
  endfunction

  task automatic modelWake(logic [31:0] mask);
    for (int m = 0; m < NM; m++) begin
      if (st[m] == 1 && (sens[m] & mask) != 0) begin
        st[m] = 2;
        q.push_back(m);
      end
    end
  endtask

  task automatic pulse(logic [31:0] mask, string tag);
    updMask = mask;
    modelWake(mask);
    step();
    updMask = '0;
    checkState(tag);
  endtask

  task automatic addSlot(int id, logic [31:0] s, string tag);
    addValid = 1'b1; addId = 4'(id); addSens = s;
    if (st[id] == 0) begin st[id] = 1; sens[id] = s; end
    step();
    addValid = 1'b0;
    checkState(tag);
  endtask

  task automatic dispatchOne(logic [31:0] extra, output int m);
    int g;
    g = grantM();
    chk(dispValid == 1'b1, "R7 offer present", 64'(dispValid), 64'd1);
    chk(int'(dispMod) == q[0], "R4 R7 head order", 64'(dispMod), 64'(q[0]));
    chk(int'(dispTile) == g, "R8 round-robin tile", 64'(dispTile), 64'(g));
    dispReady = 1'b1;
    updMask = extra;
    m = q.pop_front();
    st[m] = 3; tl[m] = g; busyM[g] = 1; ptrM = (g + 1) % NT;
    modelWake(extra);
    step();
    dispReady = 1'b0;
    updMask = '0;
    checkState("R6 R7 after transfer");
    chk(int'(modTileVec[2*m +: 2]) == g, "R11 tile recorded",
        64'(modTileVec[2*m +: 2]), 64'(g));
  endtask

  task automatic completeTile(int t, string tag);
    doneValid = 1'b1; doneTile = 2'(t);
    if (busyM[t]) begin
      for (int m = 0; m < NM; m++) if (st[m] == 3 && tl[m] == t) st[m] = 1;
      busyM[t] = 0;
    end
    step();
    doneValid = 1'b0;
    checkState(tag);
  endtask

  task automatic drainAll();
    int m;
    for (int k = 0; k < NM && q.size() > 0; k++) begin
      dispatchOne('0, m);
      completeTile(tl[m], "R10 completion returns to wait");
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int m;
    for (int i = 0; i < NM; i++) begin st[i] = 0; tl[i] = 0; sens[i] = '0; end
    for (int i = 0; i < NT; i++) busyM[i] = 0;
    rstN = 1'b0; updMask = '0; addValid = 1'b0; addId = '0; addSens = '0;
    dispReady = 1'b0; doneValid = 1'b0; doneTile = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step();
    // R1
    checkState("R1 reset state");
    chk(dispValid == 1'b0, "R1 no offer after reset", 64'(dispValid), 64'd0);

    // R2: install twelve slots, leave four free
    for (int i = 0; i < 12; i++) addSlot(i, sensOf(i), "R2 add free slot");
    pulse(32'h0008_0000, "R2 free slots not woken");
    for (int i = 12; i < NM; i++) addSlot(i, sensOf(i), "R2 runtime add");
    addSlot(5, 32'h0200_0000, "R2 add to occupied ignored");
    pulse(32'h0200_0000, "R2 occupied sensitivity unchanged");

    // R3 / R5: sweep every signal
    for (int s = 0; s < 32; s++) begin
      pulse(32'h1 << s, "R3 single signal wake");
      pulse(32'h1 << s, "R5 repeat event not requeued");
      if (q.size() > 0) begin
        dispatchOne('0, m);
        pulse(sens[m], "R5 running module ignores event");
        completeTile(tl[m], "R10 completion");
      end
      drainAll();
    end

    // R4: several signals in one cycle
    for (int k = 0; k < 6; k++) begin
      pulse((32'h1 << ((k * 3) % 16)) | (32'h1 << ((k * 5 + 1) % 16)) |
            (32'h1_0000 << (k % 4)), "R4 multi-signal wake");
      drainAll();
    end

    // R9: fill every tile
    pulse(32'h000F_0000, "R4 wake all slots");
    for (int i = 0; i < NT; i++) dispatchOne('0, m);
    chk(dispValid == 1'b0, "R9 no offer when tiles full", 64'(dispValid), 64'd0);
    chk(int'(readyCount) == NM - NT, "R9 queue kept", 64'(readyCount), 64'(NM - NT));
    completeTile(2, "R10 completion on busy tile");
    completeTile(2, "R10 completion on idle tile ignored");
    // R6: wake the returned module in the same cycle as a transfer
    for (int i = 0; i < NM; i++) if (st[i] == 1) m = i;
    begin
      int w;
      w = m;
      dispatchOne(sens[w] & (32'h1 << w), m);
      chk(q.size() > 0 && q[q.size()-1] == w, "R6 same-cycle wake queued last",
          64'(q[q.size()-1]), 64'(w));
    end
    for (int t = 0; t < NT; t++) completeTile(t, "R10 release tiles");
    drainAll();
    checkState("R10 all returned to wait");
    finishRun();
  end
endmodule